// File: doc/BRIEF.md
# Spike Fan-Out Synapse Fetch Engine

This engine expands one spike into the list of actions it causes. A source is named by an index and a flag that says whether it is an input axon or a neuron. The engine reads that source's packed pointer from a connectivity table held in a 256-bit row memory. It decodes the pointer into a row count and a start offset. It then reads each synapse row at the synapse base plus that offset and scans the eight 32-bit entries of every row in order.

Each entry becomes one of three things. It can be a weighted update for a target neuron, a spike report for the host, or nothing. Updates and reports leave on two separate valid/ready streams, and either stream may stall the scan without losing an entry. The memory is reached through a request/response port. Only one request is outstanding at a time, and the response latency is arbitrary. A one-cycle completion pulse closes each source, after which the next source may be accepted.

Top module: `spike_fanout_fetch`

## Requirements
- R1: `src_ready` is high only while the engine is idle. A source is taken on a cycle with `src_valid` and `src_ready` both high. For index i, the pointer row is 0x0000 + i/8 when `src_is_neuron`=0 and 0x4000 + i/8 when `src_is_neuron`=1. The pointer is entry i%8 of that row, and entry k occupies row bits [32k+31:32k].
- R2: A pointer word holds the row count in bits [31:23] and the start offset in bits [22:0]. The engine reads synapse rows 0x8000+start through 0x8000+start+count-1 in increasing order and scans entries 0 to 7 of each row.
- R3: A synapse word with bits [31:29] = 000 emits one update whose target is bits [28:16] and whose signed weight is bits [15:0].
- R4: A synapse word with bits [31:29] = 100 emits one host report carrying bits [28:16]. Its weight bits have no effect on any output.
- R5: An all-zero synapse word emits nothing on either stream.
- R6: A synapse word with any other opcode emits nothing and sets `bad_opcode`, which then stays high until reset. Words with opcode 000 or 100 never set it.
- R7: A pointer with a row count of 0 finishes the source with `done` and issues no synapse-row request.
- R8: While a stream is stalled (valid high, ready low), its valid and data hold. Every expected entry appears once on its stream, in scan order.
- R9: `done` is a single-cycle pulse. It is raised only after every entry of the source has been transferred on its stream.
- R10: At most one memory request is outstanding. `mem_req_valid` and `mem_req_addr` hold until the request is accepted, and each response is taken on the single cycle that `mem_rsp_valid` is high.
- R11: After reset, `src_ready` is 1, while `mem_req_valid`, `upd_valid`, `host_valid`, `done` and `bad_opcode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Spike source offered |
| src_ready | output | 1 | Engine idle and able to take a source |
| src_is_neuron | input | 1 | 1: neuron pointer table, 0: axon pointer table |
| src_idx | input | SRC_W | Source index |
| mem_req_valid | output | 1 | Row read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Row address requested |
| mem_rsp_valid | input | 1 | Row data returned (one cycle) |
| mem_rsp_data | input | 256 | Returned row |
| upd_valid | output | 1 | Neuron update available |
| upd_ready | input | 1 | Update consumer ready |
| upd_target | output | 13 | Target neuron index |
| upd_weight | output | 16 | Signed weight |
| host_valid | output | 1 | Host spike report available |
| host_ready | input | 1 | Host consumer ready |
| host_neuron | output | 13 | Reported neuron index |
| done | output | 1 | One-cycle end-of-source pulse |
| bad_opcode | output | 1 | Sticky illegal-opcode flag |

## Verification
The bench builds the engine with its default parameters: a 24-bit row address, table bases at 0x0000, 0x4000 and 0x8000, and a 14-bit source index. These values let it reach pointer slot 7 in both tables, the full 9-bit row count of 511, and start offsets near the top of the 23-bit field without wrapping the address. Random sources run with random stream backpressure and random memory latency. Directed cases cover zero-length pointers, zero entries, reports with non-zero weights and illegal opcodes.

// File: rtl/fanout_pkg.sv
package fanout_pkg;

    localparam int ENTRY_W       = 32;
    localparam int SLOTS_PER_ROW = 8;
    localparam int ROW_W         = ENTRY_W * SLOTS_PER_ROW;
    localparam int SLOT_IDX_W    = $clog2(SLOTS_PER_ROW);

    localparam int LEN_W   = 9;
    localparam int START_W = ENTRY_W - LEN_W;
    localparam int OP_W    = 3;
    localparam int TGT_W   = 13;
    localparam int WGT_W   = ENTRY_W - OP_W - TGT_W;

    localparam logic [OP_W-1:0] OP_DELIVER = 3'b000;
    localparam logic [OP_W-1:0] OP_REPORT  = 3'b100;

    typedef struct packed {
        logic [LEN_W-1:0]   rows;
        logic [START_W-1:0] offset;
    } ptr_word_t;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [TGT_W-1:0] target;
        logic [WGT_W-1:0] weight;
    } syn_word_t;

    typedef enum logic [1:0] {
        CMD_SKIP,
        CMD_UPDATE,
        CMD_REPORT,
        CMD_ILLEGAL
    } syn_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR_REQ,
        ST_PTR_WAIT,
        ST_ROW_REQ,
        ST_ROW_WAIT,
        ST_SCAN,
        ST_DRAIN
    } walk_state_e;

endpackage

// File: rtl/fo_slot_sel.sv
module fo_slot_sel #(
    parameter int N     = 8,
    parameter int W     = 32,
    parameter int SEL_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*W-1:0] row,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]   entry
);

    logic [W-1:0] slots [N];

    for (genvar g = 0; g < N; g++) begin : g_slice
        assign slots[g] = row[g*W +: W];
    end

    assign entry = slots[sel];

endmodule

// File: rtl/fo_syn_decode.sv
module fo_syn_decode
    import fanout_pkg::*;
(
    input  logic [ENTRY_W-1:0] word,
    output syn_cmd_e           cmd
);

    syn_word_t syn;
    assign syn = syn_word_t'(word);

    always_comb begin
        if (word == '0) begin
            cmd = CMD_SKIP;
        end else if (syn.op == OP_DELIVER) begin
            cmd = CMD_UPDATE;
        end else if (syn.op == OP_REPORT) begin
            cmd = CMD_REPORT;
        end else begin
            cmd = CMD_ILLEGAL;
        end
    end

endmodule

// File: rtl/fo_out_reg.sv
module fo_out_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         can_load,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready
);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } hold_t;

    hold_t q, d;

    assign can_load  = !q.valid || out_ready;
    assign out_valid = q.valid;
    assign out_data  = q.data;

    always_comb begin
        d = q;
        if (q.valid && out_ready) begin
            d.valid = 1'b0;
        end
        if (load) begin
            d.valid = 1'b1;
            d.data  = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/spike_fanout_fetch.sv
module spike_fanout_fetch
    import fanout_pkg::*;
#(
    parameter int unsigned            ADDR_W      = 24,
    parameter int unsigned            SRC_W       = 14,
    parameter logic [ADDR_W-1:0]      AXON_BASE   = 24'h00_0000,
    parameter logic [ADDR_W-1:0]      NEURON_BASE = 24'h00_4000,
    parameter logic [ADDR_W-1:0]      SYN_BASE    = 24'h00_8000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 src_valid,
    output logic                 src_ready,
    input  logic                 src_is_neuron,
    input  logic [SRC_W-1:0]     src_idx,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [ADDR_W-1:0]    mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [255:0]         mem_rsp_data,
    output logic                 upd_valid,
    input  logic                 upd_ready,
    output logic [12:0]          upd_target,
    output logic [15:0]          upd_weight,
    output logic                 host_valid,
    input  logic                 host_ready,
    output logic [12:0]          host_neuron,
    output logic                 done,
    output logic                 bad_opcode
);

    localparam logic [SLOT_IDX_W-1:0] LAST_SLOT = SLOT_IDX_W'(SLOTS_PER_ROW - 1);
    localparam int                    UPD_W     = TGT_W + WGT_W;

    typedef struct packed {
        walk_state_e             state;
        logic [SLOT_IDX_W-1:0]   ptr_slot;
        logic [ADDR_W-1:0]       row_addr;
        logic [LEN_W-1:0]        rows_left;
        logic [ROW_W-1:0]        row_buf;
        logic [SLOT_IDX_W-1:0]   scan_slot;
        logic                    done;
        logic                    err;
    } walk_t;

    walk_t q, d;

    logic [ENTRY_W-1:0] ptr_raw;
    logic [ENTRY_W-1:0] syn_raw;
    ptr_word_t          ptr_w;
    syn_word_t          syn_w;
    syn_cmd_e           cur_cmd;
    logic               upd_load, host_load;
    logic               upd_can, host_can;
    logic               step;

    fo_slot_sel #(.N(SLOTS_PER_ROW), .W(ENTRY_W)) u_ptr_sel (
        .row   (mem_rsp_data),
        .sel   (q.ptr_slot),
        .entry (ptr_raw)
    );

    fo_slot_sel #(.N(SLOTS_PER_ROW), .W(ENTRY_W)) u_syn_sel (
        .row   (q.row_buf),
        .sel   (q.scan_slot),
        .entry (syn_raw)
    );

    assign ptr_w = ptr_word_t'(ptr_raw);
    assign syn_w = syn_word_t'(syn_raw);

    fo_syn_decode u_dec (
        .word (syn_raw),
        .cmd  (cur_cmd)
    );

    fo_out_reg #(.W(UPD_W)) u_upd_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (upd_load),
        .din       ({syn_w.target, syn_w.weight}),
        .can_load  (upd_can),
        .out_valid (upd_valid),
        .out_data  ({upd_target, upd_weight}),
        .out_ready (upd_ready)
    );

    fo_out_reg #(.W(TGT_W)) u_host_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (host_load),
        .din       (syn_w.target),
        .can_load  (host_can),
        .out_valid (host_valid),
        .out_data  (host_neuron),
        .out_ready (host_ready)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        upd_load  = 1'b0;
        host_load = 1'b0;
        step      = 1'b0;

        case (q.state)
            ST_IDLE: begin
                if (src_valid) begin
                    d.row_addr = (src_is_neuron ? NEURON_BASE : AXON_BASE)
                               + ADDR_W'(src_idx >> SLOT_IDX_W);
                    d.ptr_slot = src_idx[SLOT_IDX_W-1:0];
                    d.state    = ST_PTR_REQ;
                end
            end

            ST_PTR_REQ: begin
                if (mem_req_ready) d.state = ST_PTR_WAIT;
            end

            ST_PTR_WAIT: begin
                if (mem_rsp_valid) begin
                    if (ptr_w.rows == '0) begin
                        d.done  = 1'b1;
                        d.state = ST_IDLE;
                    end else begin
                        d.row_addr  = SYN_BASE + ADDR_W'(ptr_w.offset);
                        d.rows_left = ptr_w.rows;
                        d.state     = ST_ROW_REQ;
                    end
                end
            end

            ST_ROW_REQ: begin
                if (mem_req_ready) d.state = ST_ROW_WAIT;
            end

            ST_ROW_WAIT: begin
                if (mem_rsp_valid) begin
                    d.row_buf   = mem_rsp_data;
                    d.scan_slot = '0;
                    d.state     = ST_SCAN;
                end
            end

            ST_SCAN: begin
                case (cur_cmd)
                    CMD_SKIP: step = 1'b1;
                    CMD_ILLEGAL: begin
                        step  = 1'b1;
                        d.err = 1'b1;
                    end
                    CMD_UPDATE: begin
                        if (upd_can) begin
                            upd_load = 1'b1;
                            step     = 1'b1;
                        end
                    end
                    CMD_REPORT: begin
                        if (host_can) begin
                            host_load = 1'b1;
                            step      = 1'b1;
                        end
                    end
                    default: step = 1'b1;
                endcase

                if (step) begin
                    if (q.scan_slot == LAST_SLOT) begin
                        d.rows_left = q.rows_left - 1'b1;
                        if (q.rows_left == LEN_W'(1)) begin
                            d.state = ST_DRAIN;
                        end else begin
                            d.row_addr = q.row_addr + 1'b1;
                            d.state    = ST_ROW_REQ;
                        end
                    end else begin
                        d.scan_slot = q.scan_slot + 1'b1;
                    end
                end
            end

            ST_DRAIN: begin
                if (!upd_valid && !host_valid) begin
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end
            end

            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign src_ready     = (q.state == ST_IDLE);
    assign mem_req_valid = (q.state == ST_PTR_REQ) || (q.state == ST_ROW_REQ);
    assign mem_req_addr  = q.row_addr;
    assign done          = q.done;
    assign bad_opcode    = q.err;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!upd_valid && !host_valid));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (!upd_valid && !host_valid && !mem_req_valid));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_opcode |=> bad_opcode);

endmodule

// File: tb/tb_spike_fanout_fetch.sv
module tb_spike_fanout_fetch;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         src_valid = 1'b0;
    logic         src_ready;
    logic         src_is_neuron = 1'b0;
    logic [13:0]  src_idx = '0;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [23:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [255:0] mem_rsp_data = '0;
    logic         upd_valid;
    logic         upd_ready = 1'b0;
    logic [12:0]  upd_target;
    logic [15:0]  upd_weight;
    logic         host_valid;
    logic         host_ready = 1'b0;
    logic [12:0]  host_neuron;
    logic         done;
    logic         bad_opcode;

    always #10 clk = ~clk;

    spike_fanout_fetch dut (
        .clk(clk), .rst_n(rst_n),
        .src_valid(src_valid), .src_ready(src_ready),
        .src_is_neuron(src_is_neuron), .src_idx(src_idx),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .upd_valid(upd_valid), .upd_ready(upd_ready),
        .upd_target(upd_target), .upd_weight(upd_weight),
        .host_valid(host_valid), .host_ready(host_ready),
        .host_neuron(host_neuron),
        .done(done), .bad_opcode(bad_opcode)
    );

    logic [255:0] mem [int];
    logic [28:0]  exp_upd [$];
    logic [12:0]  exp_host [$];
    int           exp_addr [$];
    bit           exp_bad = 1'b0;

    int n_cmp = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    int upd_pct = 100, host_pct = 100, req_pct = 100, max_lat = 0;

    bit          pend = 1'b0;
    int          lat_cnt = 0;
    int          pend_addr = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    endtask

    function automatic logic [31:0] rd_entry(input int row, input int s);
        logic [255:0] r;
        r = mem.exists(row) ? mem[row] : '0;
        return r[s*32 +: 32];
    endfunction

    task automatic set_entry(input int row, input int s, input logic [31:0] v);
        logic [255:0] r;
        r = mem.exists(row) ? mem[row] : '0;
        r[s*32 +: 32] = v;
        mem[row] = r;
    endtask

    // R1 R2 R3 R4 R5 R6: expectation built from the table contents alone
    task automatic build_expect(input bit is_n, input int idx);
        int prow, len, st, row;
        logic [31:0] pw, w;
        prow = (is_n ? 'h4000 : 0) + idx / 8;
        exp_addr.push_back(prow);
        pw  = rd_entry(prow, idx % 8);
        len = int'(pw[31:23]);
        st  = int'(pw[22:0]);
        for (int r = 0; r < len; r++) begin
            row = 'h8000 + st + r;
            exp_addr.push_back(row);
            for (int s = 0; s < 8; s++) begin
                w = rd_entry(row, s);
                if (w != 32'h0) begin
                    case (w[31:29])
                        3'b000:  exp_upd.push_back({w[28:16], w[15:0]});
                        3'b100:  exp_host.push_back(w[28:16]);
                        default: exp_bad = 1'b1;
                    endcase
                end
            end
        end
    endtask

    task automatic run_source(input bit is_n, input int idx, input string tag);
        int waited;
        build_expect(is_n, idx);
        while (!src_ready) @(negedge clk);
        src_valid     = 1'b1;
        src_is_neuron = is_n;
        src_idx       = 14'(idx);
        @(negedge clk);
        src_valid = 1'b0;
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk(done, {tag, " R9 done seen"}, 64'(done), 64'd1);
        chk(exp_upd.size() == 0, {tag, " R8 updates missing"}, 64'(exp_upd.size()), 64'd0);
        chk(exp_host.size() == 0, {tag, " R8 reports missing"}, 64'(exp_host.size()), 64'd0);
        chk(exp_addr.size() == 0, {tag, " R2 row fetches missing"}, 64'(exp_addr.size()), 64'd0);
        chk(bad_opcode == exp_bad, {tag, " R6 error flag"}, 64'(bad_opcode), 64'(exp_bad));
        @(negedge clk);
        chk(!done, {tag, " R9 single-cycle done"}, 64'(done), 64'd0);
        exp_upd.delete();
        exp_host.delete();
        exp_addr.delete();
    endtask

    // Cycle-level monitor and memory responder, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 190000);
            summary();
        end
        if (rst_n) begin
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (lat_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : '0;
                    pend = 1'b0;
                end else begin
                    lat_cnt--;
                end
            end
            mem_req_ready = ($urandom % 100) < req_pct;
            if (mem_req_valid && mem_req_ready) begin
                chk(!pend, "R10 second request outstanding", 64'(pend), 64'd0);
                if (exp_addr.size() == 0) begin
                    chk(1'b0, "R1 R2 unexpected request", 64'(mem_req_addr), 64'd0);
                end else begin
                    chk(int'(mem_req_addr) == exp_addr[0], "R1 R2 R10 request address",
                        64'(mem_req_addr), 64'(exp_addr[0]));
                    void'(exp_addr.pop_front());
                end
                pend      = 1'b1;
                lat_cnt   = $urandom_range(max_lat, 0);
                pend_addr = int'(mem_req_addr);
            end
            upd_ready = ($urandom % 100) < upd_pct;
            if (upd_valid && upd_ready) begin
                if (exp_upd.size() == 0) begin
                    chk(1'b0, "R3 R5 unexpected update", 64'({upd_target, upd_weight}), 64'd0);
                end else begin
                    chk({upd_target, upd_weight} == exp_upd[0], "R3 R8 update",
                        64'({upd_target, upd_weight}), 64'(exp_upd[0]));
                    void'(exp_upd.pop_front());
                end
            end
            host_ready = ($urandom % 100) < host_pct;
            if (host_valid && host_ready) begin
                if (exp_host.size() == 0) begin
                    chk(1'b0, "R4 R5 unexpected report", 64'(host_neuron), 64'd0);
                end else begin
                    chk(host_neuron == exp_host[0], "R4 R8 report",
                        64'(host_neuron), 64'(exp_host[0]));
                    void'(exp_host.pop_front());
                end
            end
        end
    end

    function automatic logic [31:0] mk_ptr(input int len, input int st);
        return {9'(len), 23'(st)};
    endfunction

    function automatic logic [31:0] mk_syn(input int op, input int tgt, input int wgt);
        return {3'(op), 13'(tgt), 16'(wgt)};
    endfunction

    task automatic set_knobs(input int u, input int h, input int r, input int l);
        upd_pct = u; host_pct = h; req_pct = r; max_lat = l;
    endtask

    task automatic rand_test();
        bit is_n;
        int idx, len, st, prow, k, op;
        mem.delete();
        is_n = 1'($urandom % 2);
        idx  = $urandom_range(16383, 0);
        len  = $urandom_range(3, 0);
        st   = $urandom_range('h7FFF0, 0);
        prow = (is_n ? 'h4000 : 0) + idx / 8;
        for (int s = 0; s < 8; s++) set_entry(prow, s, $urandom);
        set_entry(prow, idx % 8, mk_ptr(len, st));
        for (int r = 0; r < len; r++) begin
            for (int s = 0; s < 8; s++) begin
                k = $urandom % 10;
                if (k < 3) begin
                    set_entry('h8000 + st + r, s, 32'h0);
                end else if (k < 7) begin
                    set_entry('h8000 + st + r, s, mk_syn(0, $urandom, $urandom));
                end else if (k < 9) begin
                    set_entry('h8000 + st + r, s, mk_syn(4, $urandom, $urandom));
                end else begin
                    op = $urandom_range(5, 0);
                    op = (op < 3) ? op + 1 : op + 2;
                    set_entry('h8000 + st + r, s, mk_syn(op, $urandom, $urandom));
                end
            end
        end
        set_knobs($urandom_range(100, 20), $urandom_range(100, 20),
                  $urandom_range(100, 30), $urandom_range(4, 0));
        run_source(is_n, idx, "RAND");
    endtask

    initial begin
        void'($urandom(32'h1F0A_5EED));
        repeat (3) @(negedge clk);
        // R11: reset values while reset is held
        @(posedge clk);
        @(negedge clk);
        chk(src_ready == 1'b1, "R11 src_ready", 64'(src_ready), 64'd1);
        chk(!mem_req_valid, "R11 mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk(!upd_valid && !host_valid, "R11 stream valids", 64'({upd_valid, host_valid}), 64'd0);
        chk(!done && !bad_opcode, "R11 done/bad", 64'({done, bad_opcode}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R5: axon 0, one row of five updates and three zero slots
        mem.delete();
        set_entry('h0000, 0, mk_ptr(1, 0));
        for (int s = 0; s < 5; s++) set_entry('h8000, s, mk_syn(0, s, 1000));
        set_knobs(100, 100, 100, 0);
        run_source(1'b0, 0, "R5");

        // R4: neuron 13 (row 0x4001, slot 5), report with non-zero weight
        mem.delete();
        set_entry('h4001, 5, mk_ptr(1, 'h12));
        set_entry('h8012, 0, mk_syn(4, 13, 'h1234));
        set_entry('h8012, 3, mk_syn(0, 77, 'hFC18));
        set_knobs(100, 100, 60, 3);
        run_source(1'b1, 13, "R4");

        // R7: slot 7 pointer with zero length
        mem.delete();
        for (int s = 0; s < 7; s++) set_entry('h0000, s, mk_ptr(2, s));
        set_entry('h0000, 7, mk_ptr(0, 'h55));
        set_entry('h8055, 0, mk_syn(0, 1, 1));
        set_knobs(100, 100, 100, 2);
        run_source(1'b0, 7, "R7");

        // R8: three full rows under heavy backpressure
        mem.delete();
        set_entry('h4000 + 1023, 2, mk_ptr(3, 'h200));
        for (int r = 0; r < 3; r++)
            for (int s = 0; s < 8; s++)
                set_entry('h8200 + r, s, (s % 3 == 2) ? mk_syn(4, r * 8 + s, 0)
                                                     : mk_syn(0, r * 8 + s, -s));
        set_knobs(20, 25, 40, 4);
        run_source(1'b1, 1023 * 8 + 2, "R8");
        chk(!bad_opcode, "R6 flag clear after legal opcodes", 64'(bad_opcode), 64'd0);

        // R6: illegal opcodes mixed with legal ones
        mem.delete();
        set_entry('h0003, 4, mk_ptr(1, 'h40));
        set_entry('h8040, 0, mk_syn(2, 9, 9));
        set_entry('h8040, 1, mk_syn(0, 10, 10));
        set_entry('h8040, 2, mk_syn(7, 11, 11));
        set_entry('h8040, 3, mk_syn(4, 12, 0));
        set_knobs(100, 100, 100, 1);
        run_source(1'b0, 3 * 8 + 4, "R6");

        // R6 sticky, R2: maximum row count near the top of the offset field
        mem.delete();
        set_entry('h4000 + 2047, 7, mk_ptr(511, 'h7FFE00));
        set_entry('h8000 + 'h7FFE00, 0, mk_syn(0, 8191, 'h7FFF));
        set_entry('h8000 + 'h7FFE00 + 250, 4, mk_syn(4, 4096, 'hFFFF));
        set_entry('h8000 + 'h7FFE00 + 510, 7, mk_syn(0, 3, 'h8000));
        set_knobs(100, 100, 100, 0);
        run_source(1'b1, 2047 * 8 + 7, "R2");

        for (int t = 0; t < 60; t++) rand_test();

        summary();
    end

endmodule